// File: doc/BRIEF.md
# Three-Operand Integer Operate Unit

This block executes the register-to-register integer instructions of a 64-bit load/store machine whose instructions are all 32 bits wide. Each accepted instruction names two source registers, A and B, and a destination C. The unit reads A and B from a private 32-entry, 64-bit integer register file, applies one arithmetic, compare or logical operation, and writes the 64-bit result to C. No flags or status are kept: the destination register is the only place a result lands.

Instead of register B, an instruction can carry an 8-bit unsigned constant, which is zero-extended to 64 bits before use. Register 31 is a permanent zero: it reads as zero and any write to it is dropped. The result leaves on a writeback port one cycle after the instruction is taken and is stored into the register file on the following edge. An instruction that reads the register being written in that cycle sees the new value through a forwarding path, so dependent instructions can issue back to back.

Top module: `int_op_unit`

## Requirements
- R1: Instruction fields are decoded from fixed positions: major opcode in bits 31:26, source A in bits 25:21, source B in bits 20:16, function in bits 11:5 and destination C in bits 4:0.
- R2: An instruction accepted on a clock edge with `instr_valid` high produces `wb_valid` high, `wb_addr` equal to C and `wb_data` equal to A op B after that same edge, and the result is stored in register C for later reads.
- R3: Register 31 always reads as zero; a result aimed at it still appears on the writeback port but leaves its value at zero.
- R4: When bit 12 is set, bits 20:13 form an unsigned literal that is zero-extended to 64 bits and used as operand B in place of a register.
- R5: Opcode 0x10 with function 0x00 adds, with function 0x01 subtracts (A minus B), and opcode 0x13 with function 0x00 multiplies; each keeps the low 64 bits and wraps without any trap.
- R6: Opcode 0x10 with function 0x02 (equal), 0x03 (signed less-than) and 0x04 (unsigned less-than) writes the 64-bit value 1 when the comparison holds and 0 otherwise.
- R7: Opcode 0x11 with function 0x00 to 0x05 computes in order A and B, A and not B, A or B, A or not B, A xor B, A xor not B.
- R8: An instruction whose source equals the destination on the writeback port in the cycle it is accepted reads the value being written, not the old register contents.
- R9: An unknown opcode, an unknown function within a known opcode, or `instr_valid` low produces no writeback and changes no register.
- R10: After synchronous reset, `wb_valid` is low and all 32 registers read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction on `instr` is taken at this edge |
| instr | input | 32 | Operate-format instruction word |
| wb_valid | output | 1 | Writeback port carries a result |
| wb_addr | output | 5 | Destination register of the result |
| wb_data | output | 64 | 64-bit result |

## Verification
Every operation is applied to every ordered pair drawn from a set of registers holding zero (register 31), a small positive, a full byte, a negative number and two values that use all 64 bits after wrapping multiplies; equal pairs separate equality from the orderings, and the negative and large values separate signed from unsigned comparison and expose any lost upper bits. The same operations are then repeated with literal constants including 0, 255 and 128, which would turn negative if sign-extended. Back-to-back dependent instructions tell the forwarding path apart from a stale register read, and reads of register 31 after a write to it, plus unknown codes followed by a read of their target, show that dropped writes really touch nothing.

// File: rtl/iop_pkg.sv
package iop_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 7;
    localparam int RIDX_W  = 5;
    localparam int LIT_W   = 8;

    localparam logic [OPC_W-1:0] OPC_ARITH = 6'h10;
    localparam logic [OPC_W-1:0] OPC_LOGIC = 6'h11;
    localparam logic [OPC_W-1:0] OPC_MULT  = 6'h13;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_MUL,
        ALU_CEQ, ALU_CLT, ALU_CULT,
        ALU_AND, ALU_ANDN, ALU_OR, ALU_ORN, ALU_XOR, ALU_XNOR
    } alu_op_e;

    typedef struct packed {
        logic              legal;
        alu_op_e           op;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] src_b;
        logic [RIDX_W-1:0] dst;
        logic              use_lit;
        logic [LIT_W-1:0]  lit;
    } dec_t;

    function automatic dec_t decode(input logic [INSTR_W-1:0] w);
        dec_t d;
        logic [OPC_W-1:0] opc;
        logic [FN_W-1:0]  fn;
        opc       = w[31:26];
        fn        = w[11:5];
        d.src_a   = w[25:21];
        d.src_b   = w[20:16];
        d.dst     = w[4:0];
        d.use_lit = w[12];
        d.lit     = w[20:13];
        d.legal   = 1'b1;
        d.op      = ALU_ADD;
        unique case (opc)
            OPC_ARITH: begin
                unique case (fn)
                    7'h00:   d.op = ALU_ADD;
                    7'h01:   d.op = ALU_SUB;
                    7'h02:   d.op = ALU_CEQ;
                    7'h03:   d.op = ALU_CLT;
                    7'h04:   d.op = ALU_CULT;
                    default: d.legal = 1'b0;
                endcase
            end
            OPC_LOGIC: begin
                unique case (fn)
                    7'h00:   d.op = ALU_AND;
                    7'h01:   d.op = ALU_ANDN;
                    7'h02:   d.op = ALU_OR;
                    7'h03:   d.op = ALU_ORN;
                    7'h04:   d.op = ALU_XOR;
                    7'h05:   d.op = ALU_XNOR;
                    default: d.legal = 1'b0;
                endcase
            end
            OPC_MULT: begin
                if (fn == 7'h00) d.op = ALU_MUL;
                else             d.legal = 1'b0;
            end
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic is_compare(input alu_op_e op);
        return (op == ALU_CEQ) || (op == ALU_CLT) || (op == ALU_CULT);
    endfunction

endpackage

// File: rtl/iop_decoder.sv
module iop_decoder
    import iop_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    always_comb dec = decode(instr);
endmodule

// File: rtl/iop_alu.sv
module iop_alu
    import iop_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    logic [XLEN-1:0] prod;
    assign prod = a * b;

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_MUL:  y = prod;
            ALU_CEQ:  y = (a == b) ? ONE : '0;
            ALU_CLT:  y = ($signed(a) < $signed(b)) ? ONE : '0;
            ALU_CULT: y = (a < b) ? ONE : '0;
            ALU_AND:  y = a & b;
            ALU_ANDN: y = a & ~b;
            ALU_OR:   y = a | b;
            ALU_ORN:  y = a | ~b;
            ALU_XOR:  y = a ^ b;
            ALU_XNOR: y = a ^ ~b;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/iop_regfile.sv
module iop_regfile #(
    parameter int XLEN   = 64,
    parameter int NREG   = 32,
    parameter int NREAD  = 2,
    localparam int AW    = $clog2(NREG),
    localparam int NSTORE = NREG - 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [XLEN-1:0]            wr_data,
    input  logic [NREAD-1:0][AW-1:0]   rd_addr,
    output logic [NREAD-1:0][XLEN-1:0] rd_data
);
    localparam logic [AW-1:0] ZERO_IDX = AW'(NREG - 1);

    logic [XLEN-1:0] mem [NSTORE];

    for (genvar g = 0; g < NSTORE; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                                   mem[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))       mem[g] <= wr_data;
        end
    end

    for (genvar p = 0; p < NREAD; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] == ZERO_IDX)
                rd_data[p] = '0;
            else if (wr_en && wr_addr == rd_addr[p])
                rd_data[p] = wr_data;
            else
                rd_data[p] = mem[rd_addr[p]];
        end

        // R3: the permanent zero register never reads non-zero
        a_r3_zero_source: assert property (@(posedge clk) disable iff (rst)
            rd_addr[p] == ZERO_IDX |-> rd_data[p] == '0);
    end

    // R2: a stored result is held in the entry it was written to
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr != ZERO_IDX |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/int_op_unit.sv
module int_op_unit
    import iop_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_addr,
    output logic [XLEN-1:0] wb_data
);
    dec_t                     dec;
    logic [1:0][AW-1:0]       rd_addr;
    logic [1:0][XLEN-1:0]     rd_data;
    logic [XLEN-1:0]          opnd_b;
    logic [XLEN-1:0]          result;

    iop_decoder u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign rd_addr[0] = AW'(dec.src_a);
    assign rd_addr[1] = AW'(dec.src_b);

    iop_regfile #(.XLEN(XLEN), .NREG(NREG), .NREAD(2)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wb_valid),
        .wr_addr (wb_addr),
        .wr_data (wb_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign opnd_b = dec.use_lit ? XLEN'(dec.lit) : rd_data[1];

    iop_alu #(.XLEN(XLEN)) u_alu (
        .op (dec.op),
        .a  (rd_data[0]),
        .b  (opnd_b),
        .y  (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= instr_valid && dec.legal;
            wb_addr  <= AW'(dec.dst);
            wb_data  <= result;
        end
    end

    // R2: a legal accepted instruction writes back to its destination next cycle
    a_r2_wb_follows: assert property (@(posedge clk) disable iff (rst)
        instr_valid && dec.legal |=> wb_valid && wb_addr == $past(AW'(dec.dst)));

    // R9: nothing is written back without a legal accepted instruction
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(instr_valid && dec.legal) |=> !wb_valid);

    // R4: the literal operand never carries bits above its 8-bit field
    a_r4_lit_zero_ext: assert property (@(posedge clk) disable iff (rst)
        instr_valid && dec.use_lit |-> opnd_b[XLEN-1:LIT_W] == '0);

    // R6: compare results written back are 0 or 1
    a_r6_cmp_bool: assert property (@(posedge clk) disable iff (rst)
        instr_valid && dec.legal && is_compare(dec.op) |=> wb_data[XLEN-1:1] == '0);

endmodule

// File: tb/int_op_unit_test.sv
module int_op_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        wb_valid;
    logic [4:0]  wb_addr;
    logic [63:0] wb_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic [63:0] model [32];

    always #2.5 clk = ~clk;

    int_op_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] k_opc(input int k);
        if (k == 2) return 6'h13;
        if (k >= 6) return 6'h11;
        return 6'h10;
    endfunction

    function automatic logic [6:0] k_fn(input int k);
        case (k)
            0: return 7'd0;  1: return 7'd1;  2: return 7'd0;
            3: return 7'd2;  4: return 7'd3;  5: return 7'd4;
            default: return 7'(k - 6);
        endcase
    endfunction

    function automatic string k_req(input int k);
        if (k <= 2) return "R5";
        if (k <= 5) return "R6";
        return "R7";
    endfunction

    function automatic logic [63:0] ref_op(input int k, input logic [63:0] a, input logic [63:0] b);
        case (k)
            0: return a + b;
            1: return a - b;
            2: return a * b;
            3: return (a == b) ? 64'd1 : 64'd0;
            4: return ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
            5: return (a < b) ? 64'd1 : 64'd0;
            6: return a & b;
            7: return a & ~b;
            8: return a | b;
            9: return a | ~b;
            10: return a ^ b;
            default: return a ^ ~b;
        endcase
    endfunction

    function automatic logic [31:0] mk_reg(input int k, input int ra, input int rb, input int rc);
        return {k_opc(k), 5'(ra), 5'(rb), 3'b000, 1'b0, k_fn(k), 5'(rc)};
    endfunction

    function automatic logic [31:0] mk_lit(input int k, input int ra, input logic [7:0] lit, input int rc);
        return {k_opc(k), 5'(ra), lit, 1'b1, k_fn(k), 5'(rc)};
    endfunction

    // Drive at a falling edge, take at the rising edge, check at the next falling edge.
    task automatic issue(input logic [31:0] w, input bit exp_v, input logic [63:0] exp_d, input string req);
        instr       = w;
        instr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(wb_valid == exp_v, {req, " wb_valid"}, 64'(wb_valid), 64'(exp_v));
        if (exp_v) begin
            chk(wb_addr == w[4:0], {req, " wb_addr"}, 64'(wb_addr), 64'(w[4:0]));
            chk(wb_data == exp_d, {req, " wb_data"}, wb_data, exp_d);
        end
    endtask

    task automatic run_reg(input int k, input int ra, input int rb, input int rc, input string req);
        logic [63:0] e;
        e = ref_op(k, model[ra], model[rb]);
        issue(mk_reg(k, ra, rb, rc), 1'b1, e, req);
        if (rc != 31) model[rc] = e;
    endtask

    task automatic run_lit(input int k, input int ra, input logic [7:0] lit, input int rc, input string req);
        logic [63:0] e;
        e = ref_op(k, model[ra], {56'd0, lit});
        issue(mk_lit(k, ra, lit, rc), 1'b1, e, req);
        if (rc != 31) model[rc] = e;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int srcs [6];
        logic [7:0] lits [5];
        srcs = '{1, 2, 3, 4, 5, 31};
        lits = '{8'd0, 8'd1, 8'd3, 8'd128, 8'd255};
        for (int i = 0; i < 32; i++) model[i] = '0;

        repeat (4) @(negedge clk);
        chk(wb_valid == 1'b0, "R10 wb_valid in reset", 64'(wb_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(wb_valid == 1'b0, "R10 wb_valid after reset", 64'(wb_valid), 64'd0);

        // R10: every register reads zero after reset (read through OR into R31)
        for (int r = 0; r < 32; r++) run_reg(8, r, 31, 31, "R10");

        // R6: comparing zero with literal 3 for equality yields 0
        run_lit(3, 31, 8'd3, 6, "R6");

        // Build operands (R1 R2 R4 R5 R4/R5 wrap, R3 negative); R4 R5
        run_lit(0, 31, 8'd200, 1, "R4");
        run_lit(0, 31, 8'd255, 2, "R4");
        run_lit(1, 31, 8'd5, 3, "R5");
        run_reg(2, 2, 2, 4, "R5");
        run_reg(2, 4, 4, 4, "R5");
        run_reg(2, 4, 4, 4, "R5");
        run_reg(2, 4, 3, 5, "R5");
        run_reg(0, 5, 4, 5, "R5");

        // R1 R2: full sweep over operations and register pairs
        for (int k = 0; k < 12; k++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    run_reg(k, srcs[i], srcs[j], 20 + (k % 8), k_req(k));

        // R4: literal mode sweep
        for (int k = 0; k < 12; k++)
            for (int i = 0; i < 6; i++)
                for (int l = 0; l < 5; l++)
                    run_lit(k, srcs[i], lits[l], 28, "R4");

        // R2: stored results readable later
        for (int r = 20; r < 29; r++) run_reg(8, r, 31, 31, "R2");

        // R8: dependent instructions back to back
        run_lit(0, 31, 8'd7, 20, "R8");
        run_lit(0, 20, 8'd1, 21, "R8");
        run_reg(1, 21, 20, 22, "R8");
        run_reg(2, 22, 21, 22, "R8");
        run_reg(0, 22, 22, 23, "R8");

        // R3: write to R31 shows on the port but is dropped
        run_lit(0, 31, 8'd9, 31, "R3");
        run_reg(8, 31, 31, 24, "R3");
        run_lit(8, 31, 8'd0, 25, "R3");

        // R9: unknown opcode, unknown function, and idle leave registers alone
        issue({6'h3F, 5'd31, 8'd77, 1'b1, 7'd0, 5'd1}, 1'b0, '0, "R9");
        issue({6'h10, 5'd31, 8'd77, 1'b1, 7'h7F, 5'd2}, 1'b0, '0, "R9");
        issue({6'h11, 5'd31, 8'd77, 1'b1, 7'h06, 5'd3}, 1'b0, '0, "R9");
        instr       = mk_lit(0, 31, 8'd99, 4);
        instr_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(wb_valid == 1'b0, "R9 idle wb_valid", 64'(wb_valid), 64'd0);
        for (int r = 1; r < 5; r++) run_reg(8, r, 31, 31, "R9");

        instr_valid = 1'b0;
        @(negedge clk);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule